// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command side of a 16-bit mobile SDRAM interface from the device's point of view. On every rising clock edge it samples clock enable, the four active-low command strobes, the two bank-select bits, the thirteen address bits and the two byte-lane masks. It turns each strobe pattern into a command and keeps, for each of the four banks, an open/closed flag and the row last opened there. It also follows read and write bursts of four beats, including auto-precharge at the end of a burst.

When clock enable is sampled low, the block picks a low-power state. The choice depends on what is happening at that moment: a burst in flight, open rows, a refresh request, or fully idle banks. It leaves that state as soon as clock enable is sampled high again. The byte masks act differently by direction. On write beats they are passed straight through as per-lane write masks. On reads they gate a per-lane output enable two clocks later. Illegal bank accesses raise a one-cycle error flag. The two mode registers are loaded from the address bus.

Power states (3-bit code on `pwr_state`): PS_NORMAL (0), PS_PRE_PD (1, precharge power-down), PS_SELF_REF (2, self refresh), PS_ACT_PD (3, active power-down), PS_SUSPEND (4, clock suspend). The transitions are:
- PS_NORMAL to PS_SUSPEND, when a burst is pending.
- PS_NORMAL to PS_ACT_PD, when any row is open.
- PS_NORMAL to PS_SELF_REF, when the command is a refresh and all banks are idle.
- PS_NORMAL to PS_PRE_PD, otherwise.
- Every low-power state back to PS_NORMAL, when clock enable is sampled high.

Each bank has a two-state machine with the states BK_IDLE and BK_ACTIVE. It goes open on an accepted activate. It goes to idle on a precharge that covers it, or on the auto-precharge of a burst that targets it.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset all banks are idle, `pwr_state` is 0, and `burst_active`, `wr_mask`, `rd_oe`, `cmd_err`, `mode_reg` and `ext_mode_reg` are zero.
- R2: With `cs_n` sampled high, no bank state, row or mode register changes and no error is raised, whatever the other strobes carry.
- R3: Strobes {cs_n,ras_n,cas_n,we_n}=0011 (activate) to an idle bank `ba` opens it and stores `addr` as its row (bank i's row at `bank_row[13*i +: 13]`). An activate to an open bank leaves its row unchanged.
- R4: A read (0101) or write (0100) to an idle bank starts no burst and raises `cmd_err`.
- R5: A read or write to an open bank starts a four-beat burst. The first beat is at the command edge and the next three beats follow on the next three enabled edges. `burst_col` shows each beat's column, starting at `addr[8:0]` and counting up in the two low bits with wrap-around. `burst_active` stays high while beats remain.
- R6: When `addr[10]` is high on a read or write, the target bank closes at the edge of the burst's final beat and not earlier.
- R7: Precharge (0010) with `addr[10]` high closes all four banks. With `addr[10]` low it closes only bank `ba`.
- R8: Mode register set (0000) loads `addr` into `ext_mode_reg` when `ba[1]` is 1 and into `mode_reg` when `ba[1]` is 0, leaving the other register unchanged.
- R9: When `cke` is sampled low in state 0, the next state is 4 if a burst is pending. Otherwise it is 3 if any row is open, 2 if the command is refresh (0001), and 1 in all other cases.
- R10: While `cke` is sampled low, commands are ignored and a pending burst freezes. The first edge with `cke` high returns `pwr_state` to 0 and resumes the burst.
- R11: On each write beat, `wr_mask` takes {udqm, ldqm} (bit 0 covers DQ[7:0], bit 1 covers DQ[15:8]). At every other edge it is 0.
- R12: After the edge two clocks past a read beat, `rd_oe[i]` is 1 unless lane i's mask was high at that beat's edge. When no read beat happened two edges back, `rd_oe` is 0.
- R13: `cmd_err` is high for exactly the cycle after an erroneous activate, read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, column, auto-precharge flag or opcode |
| ldqm | input | 1 | Low byte lane mask |
| udqm | input | 1 | High byte lane mask |
| bank_open | output | 4 | One open flag per bank |
| bank_row | output | 52 | Stored row per bank, 13 bits each |
| pwr_state | output | 3 | Power state code |
| burst_active | output | 1 | Beats of a burst still pending |
| burst_col | output | 9 | Column of the latest beat |
| wr_mask | output | 2 | Per-lane write mask of the current write beat |
| rd_oe | output | 2 | Per-lane read output enable |
| cmd_err | output | 1 | Illegal bank access in the previous cycle |
| mode_reg | output | 13 | Standard mode register |
| ext_mode_reg | output | 13 | Extended mode register |

## Verification
A wrong bank flag shows at `bank_open` right after the offending edge. It also shows one edge later as a spurious or missing `cmd_err` on the next activate or access to that bank. A burst counter that is off by one shows as a wrong `burst_col` sequence, or as the auto-precharged bank closing one edge early or late. A wrong mask pipeline depth shows as `rd_oe` patterns shifted by a clock. Power-state mistakes show at `pwr_state` on the first edge with `cke` low. A frozen burst that fails to hold shows as `burst_col` moving while `cke` is low.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef enum logic [2:0] {
        PS_NORMAL   = 3'd0,
        PS_PRE_PD   = 3'd1,
        PS_SELF_REF = 3'd2,
        PS_ACT_PD   = 3'd3,
        PS_SUSPEND  = 3'd4
    } pwr_e;

    typedef enum logic {
        BK_IDLE,
        BK_ACTIVE
    } bank_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row
);

    bank_e state, state_nx;
    logic [ROW_W-1:0] row_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            BK_IDLE:   if (open_req)  state_nx = BK_ACTIVE;
            BK_ACTIVE: if (close_req) state_nx = BK_IDLE;
            default:   state_nx = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BK_IDLE;
            row_q <= '0;
        end else begin
            state <= state_nx;
            if (state == BK_IDLE && open_req) row_q <= row_in;
        end
    end

    always_comb begin
        is_open = (state == BK_ACTIVE);
        row     = row_q;
    end

endmodule

// File: rtl/sdram_pwr_fsm.sv
module sdram_pwr_fsm
    import sdram_trk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic       busy,
    input  logic       any_open,
    input  logic       ref_req,
    output logic [2:0] pwr_state
);

    pwr_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_NORMAL: begin
                if (!cke) begin
                    if (busy)          state_nx = PS_SUSPEND;
                    else if (any_open) state_nx = PS_ACT_PD;
                    else if (ref_req)  state_nx = PS_SELF_REF;
                    else               state_nx = PS_PRE_PD;
                end
            end
            PS_PRE_PD, PS_SELF_REF, PS_ACT_PD, PS_SUSPEND: begin
                if (cke) state_nx = PS_NORMAL;
            end
            default: state_nx = PS_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_NORMAL;
        else        state <= state_nx;
    end

    always_comb begin
        pwr_state = state;
    end

endmodule

// File: rtl/sdram_burst_unit.sv
module sdram_burst_unit #(
    parameter int COL_W     = 9,
    parameter int BANK_W    = 2,
    parameter int BURST_LEN = 4,
    parameter int DQM_LAT   = 2,
    parameter int LANES     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              start,
    input  logic              start_wr,
    input  logic              start_ap,
    input  logic [BANK_W-1:0] start_bank,
    input  logic [COL_W-1:0]  start_col,
    input  logic [LANES-1:0]  dqm,
    output logic              busy,
    output logic              ap_close,
    output logic [BANK_W-1:0] ap_bank,
    output logic [COL_W-1:0]  col,
    output logic [LANES-1:0]  wr_mask,
    output logic [LANES-1:0]  rd_oe
);

    localparam int BL_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int CNT_W = BL_W + 1;

    logic [CNT_W-1:0]  cnt;
    logic              is_wr_q;
    logic              ap_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic              advance;
    logic              beat;
    logic              beat_wr;
    logic              last_beat;

    logic             rb_pipe [DQM_LAT];
    logic [LANES-1:0] dm_pipe [DQM_LAT];

    always_comb begin
        busy      = (cnt != '0);
        advance   = cke && busy;
        beat      = start || advance;
        beat_wr   = start ? start_wr : is_wr_q;
        last_beat = advance && (cnt == CNT_W'(1));
        ap_close  = ap_q && (last_beat || (start && busy));
        ap_bank   = bank_q;
        col       = col_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            is_wr_q <= 1'b0;
            ap_q    <= 1'b0;
            bank_q  <= '0;
            col_q   <= '0;
            wr_mask <= '0;
        end else begin
            if (start) begin
                cnt     <= CNT_W'(BURST_LEN - 1);
                is_wr_q <= start_wr;
                ap_q    <= start_ap;
                bank_q  <= start_bank;
                col_q   <= start_col;
            end else if (advance) begin
                cnt               <= cnt - 1'b1;
                col_q[BL_W-1:0]   <= col_q[BL_W-1:0] + 1'b1;
                if (last_beat) ap_q <= 1'b0;
            end
            wr_mask <= (beat && beat_wr) ? dqm : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < DQM_LAT; j++) begin
                rb_pipe[j] <= 1'b0;
                dm_pipe[j] <= '0;
            end
            rd_oe <= '0;
        end else begin
            rb_pipe[0] <= beat && !beat_wr;
            dm_pipe[0] <= dqm;
            for (int j = 1; j < DQM_LAT; j++) begin
                rb_pipe[j] <= rb_pipe[j-1];
                dm_pipe[j] <= dm_pipe[j-1];
            end
            rd_oe <= rb_pipe[DQM_LAT-1] ? ~dm_pipe[DQM_LAT-1] : '0;
        end
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int BANK_W    = 2,
    parameter int BURST_LEN = 4,
    parameter int DQM_LAT   = 2,
    parameter int AP_BIT    = 10,
    localparam int NBANK    = 1 << BANK_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BANK_W-1:0]      ba,
    input  logic [ROW_W-1:0]       addr,
    input  logic                   ldqm,
    input  logic                   udqm,
    output logic [NBANK-1:0]       bank_open,
    output logic [NBANK*ROW_W-1:0] bank_row,
    output logic [2:0]             pwr_state,
    output logic                   burst_active,
    output logic [COL_W-1:0]       burst_col,
    output logic [1:0]             wr_mask,
    output logic [1:0]             rd_oe,
    output logic                   cmd_err,
    output logic [ROW_W-1:0]       mode_reg,
    output logic [ROW_W-1:0]       ext_mode_reg
);

    cmd_e              cmd;
    logic [NBANK-1:0]  sel_oh;
    logic [NBANK-1:0]  open_req;
    logic [NBANK-1:0]  close_req;
    logic              tgt_open;
    logic              act_hit, rw_hit, pre_hit, mrs_hit;
    logic              rw_start;
    logic              err_d;
    logic              ap_close;
    logic [BANK_W-1:0] ap_bank;
    logic              busy;

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    always_comb begin
        sel_oh   = NBANK'(1) << ba;
        tgt_open = bank_open[ba];
        act_hit  = cke && (cmd == CMD_ACT);
        rw_hit   = cke && ((cmd == CMD_RD) || (cmd == CMD_WR));
        pre_hit  = cke && (cmd == CMD_PRE);
        mrs_hit  = cke && (cmd == CMD_MRS);
        rw_start = rw_hit && tgt_open;
        err_d    = (act_hit && tgt_open) || (rw_hit && !tgt_open);
    end

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic [ROW_W-1:0] row_i;
        always_comb begin
            open_req[i]  = act_hit && !tgt_open && sel_oh[i];
            close_req[i] = (pre_hit && (addr[AP_BIT] || sel_oh[i]))
                         || (ap_close && (ap_bank == BANK_W'(i)));
        end
        sdram_bank_slot #(.ROW_W(ROW_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (open_req[i]),
            .close_req (close_req[i]),
            .row_in    (addr),
            .is_open   (bank_open[i]),
            .row       (row_i)
        );
        assign bank_row[i*ROW_W +: ROW_W] = row_i;
    end

    sdram_burst_unit #(
        .COL_W     (COL_W),
        .BANK_W    (BANK_W),
        .BURST_LEN (BURST_LEN),
        .DQM_LAT   (DQM_LAT),
        .LANES     (2)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .start      (rw_start),
        .start_wr   (cmd == CMD_WR),
        .start_ap   (addr[AP_BIT]),
        .start_bank (ba),
        .start_col  (addr[COL_W-1:0]),
        .dqm        ({udqm, ldqm}),
        .busy       (busy),
        .ap_close   (ap_close),
        .ap_bank    (ap_bank),
        .col        (burst_col),
        .wr_mask    (wr_mask),
        .rd_oe      (rd_oe)
    );

    sdram_pwr_fsm u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .busy      (busy),
        .any_open  (|bank_open),
        .ref_req   (cmd == CMD_REF),
        .pwr_state (pwr_state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_err      <= 1'b0;
            mode_reg     <= '0;
            ext_mode_reg <= '0;
        end else begin
            cmd_err <= err_d;
            if (mrs_hit) begin
                if (ba[BANK_W-1]) ext_mode_reg <= addr;
                else              mode_reg     <= addr;
            end
        end
    end

    always_comb begin
        burst_active = busy;
    end

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10,
    localparam int NBANK = 1 << BANK_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cke,
    input logic                   cs_n,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   we_n,
    input logic [BANK_W-1:0]      ba,
    input logic [ROW_W-1:0]       addr,
    input logic [NBANK-1:0]       bank_open,
    input logic [NBANK*ROW_W-1:0] bank_row,
    input logic [2:0]             pwr_state,
    input logic                   burst_active,
    input logic [COL_W-1:0]       burst_col,
    input logic                   cmd_err
);

    logic is_act, is_rd, is_pre;
    assign is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
    assign is_rd  = !cs_n &&  ras_n && !cas_n &&  we_n;
    assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;

    a_r2_deselect_inert: assert property (@(posedge clk) disable iff (!rst_n)
        cke && cs_n && !burst_active |=> $stable(bank_open) && $stable(bank_row) && !cmd_err);

    a_r3_activate_opens: assert property (@(posedge clk) disable iff (!rst_n)
        cke && is_act && !bank_open[ba]
        |=> bank_open[$past(ba)] && (bank_row[$past(ba)*ROW_W +: ROW_W] == $past(addr)));

    a_r4_read_idle_err: assert property (@(posedge clk) disable iff (!rst_n)
        cke && is_rd && !bank_open[ba] |=> cmd_err);

    a_r7_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
        cke && is_pre && addr[AP_BIT] |=> bank_open == '0);

    a_r9_suspend_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd0) && !cke && burst_active |=> pwr_state == 3'd4);

    a_r10_cke_low_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> $stable(bank_open) && $stable(burst_col));

    a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 3'd0) && cke |=> pwr_state == 3'd0);

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .BANK_W (BANK_W),
    .AP_BIT (AP_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .ba           (ba),
    .addr         (addr),
    .bank_open    (bank_open),
    .bank_row     (bank_row),
    .pwr_state    (pwr_state),
    .burst_active (burst_active),
    .burst_col    (burst_col),
    .cmd_err      (cmd_err)
);

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;

    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_NOP = 4'b0111;

    // [29] cke [28:25] cs,ras,cas,we [24:23] ba [22:10] addr [9:8] {udqm,ldqm}
    // [7:4] expected bank_open [3:1] expected pwr_state [0] expected cmd_err
    localparam int NV = 19;
    localparam logic [29:0] VECS [NV] = '{
        {1'b1, C_ACT,   2'd0, 13'h0123, 2'b00, 4'b0001, 3'd0, 1'b0},
        {1'b1, C_ACT,   2'd2, 13'h00AB, 2'b00, 4'b0101, 3'd0, 1'b0},
        {1'b1, C_ACT,   2'd0, 13'h0777, 2'b00, 4'b0101, 3'd0, 1'b1},
        {1'b1, 4'b1010, 2'd0, 13'h0400, 2'b00, 4'b0101, 3'd0, 1'b0},
        {1'b1, C_PRE,   2'd2, 13'h0000, 2'b00, 4'b0001, 3'd0, 1'b0},
        {1'b1, C_RD,    2'd1, 13'h0010, 2'b00, 4'b0001, 3'd0, 1'b1},
        {1'b1, C_ACT,   2'd3, 13'h0005, 2'b00, 4'b1001, 3'd0, 1'b0},
        {1'b1, C_PRE,   2'd1, 13'h0400, 2'b00, 4'b0000, 3'd0, 1'b0},
        {1'b1, C_NOP,   2'd0, 13'h0000, 2'b00, 4'b0000, 3'd0, 1'b0},
        {1'b0, C_NOP,   2'd0, 13'h0000, 2'b00, 4'b0000, 3'd1, 1'b0},
        {1'b0, C_ACT,   2'd1, 13'h0042, 2'b00, 4'b0000, 3'd1, 1'b0},
        {1'b1, C_NOP,   2'd0, 13'h0000, 2'b00, 4'b0000, 3'd0, 1'b0},
        {1'b0, C_REF,   2'd0, 13'h0000, 2'b00, 4'b0000, 3'd2, 1'b0},
        {1'b1, C_NOP,   2'd0, 13'h0000, 2'b00, 4'b0000, 3'd0, 1'b0},
        {1'b1, C_ACT,   2'd1, 13'h0007, 2'b00, 4'b0010, 3'd0, 1'b0},
        {1'b0, C_NOP,   2'd0, 13'h0000, 2'b00, 4'b0010, 3'd3, 1'b0},
        {1'b1, C_NOP,   2'd0, 13'h0000, 2'b00, 4'b0010, 3'd0, 1'b0},
        {1'b1, 4'b1011, 2'd0, 13'h0999, 2'b00, 4'b0010, 3'd0, 1'b0},
        {1'b1, C_PRE,   2'd1, 13'h0000, 2'b00, 4'b0000, 3'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic        ldqm = 1'b0, udqm = 1'b0;
    logic [3:0]  bank_open;
    logic [51:0] bank_row;
    logic [2:0]  pwr_state;
    logic        burst_active;
    logic [8:0]  burst_col;
    logic [1:0]  wr_mask, rd_oe;
    logic        cmd_err;
    logic [12:0] mode_reg, ext_mode_reg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdram_cmd_tracker u_sdram_cmd_tracker (
        .clk (clk), .rst_n (rst_n), .cke (cke),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .ldqm (ldqm), .udqm (udqm),
        .bank_open (bank_open), .bank_row (bank_row), .pwr_state (pwr_state),
        .burst_active (burst_active), .burst_col (burst_col),
        .wr_mask (wr_mask), .rd_oe (rd_oe), .cmd_err (cmd_err),
        .mode_reg (mode_reg), .ext_mode_reg (ext_mode_reg)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic k, input logic [3:0] c, input logic [1:0] b,
                        input logic [12:0] a, input logic [1:0] dm);
        cke = k;
        {cs_n, ras_n, cas_n, we_n} = c;
        ba = b;
        addr = a;
        {udqm, ldqm} = dm;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 bank_open", 64'(bank_open), 64'h0);
        chk("R1 pwr_state", 64'(pwr_state), 64'h0);
        chk("R1 burst/masks/err", 64'({burst_active, wr_mask, rd_oe, cmd_err}), 64'h0);
        chk("R1 mode regs", 64'({mode_reg, ext_mode_reg}), 64'h0);

        // table walk: R2 R3 R7 R9 R10 R13
        for (int v = 0; v < NV; v++) begin
            step(VECS[v][29], VECS[v][28:25], VECS[v][24:23], VECS[v][22:10], VECS[v][9:8]);
            chk($sformatf("R2 R3 R7 R10 vec %0d bank_open", v), 64'(bank_open), 64'(VECS[v][7:4]));
            chk($sformatf("R9 R10 vec %0d pwr_state", v), 64'(pwr_state), 64'(VECS[v][3:1]));
            chk($sformatf("R13 R4 vec %0d cmd_err", v), 64'(cmd_err), 64'(VECS[v][0]));
            chk($sformatf("R4 vec %0d burst_active", v), 64'(burst_active), 64'h0);
        end
        chk("R3 row bank0 kept", 64'(bank_row[0 +: 13]), 64'h0123);
        chk("R3 row bank1", 64'(bank_row[13 +: 13]), 64'h0007);
        chk("R3 row bank2", 64'(bank_row[26 +: 13]), 64'h00AB);
        chk("R3 row bank3", 64'(bank_row[39 +: 13]), 64'h0005);

        // R8 mode registers
        step(1'b1, C_MRS, 2'd0, 13'h0032, 2'b00);
        chk("R8 standard", 64'({mode_reg, ext_mode_reg}), 64'({13'h0032, 13'h0000}));
        step(1'b1, C_MRS, 2'd2, 13'h0021, 2'b00);
        chk("R8 extended", 64'({mode_reg, ext_mode_reg}), 64'({13'h0032, 13'h0021}));

        // R5 R11 write burst with lane masks, column wrap
        step(1'b1, C_ACT, 2'd0, 13'h0001, 2'b00);
        step(1'b1, C_WR, 2'd0, 13'h0006, 2'b01);
        chk("R5 col beat0", 64'(burst_col), 64'h006);
        chk("R11 mask beat0", 64'(wr_mask), 64'h1);
        chk("R5 active beat0", 64'(burst_active), 64'h1);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b00);
        chk("R5 col beat1", 64'(burst_col), 64'h007);
        chk("R11 mask beat1", 64'(wr_mask), 64'h0);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b10);
        chk("R5 col beat2 wrap", 64'(burst_col), 64'h004);
        chk("R11 mask beat2", 64'(wr_mask), 64'h2);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b11);
        chk("R5 col beat3", 64'(burst_col), 64'h005);
        chk("R11 mask beat3", 64'(wr_mask), 64'h3);
        chk("R5 done", 64'(burst_active), 64'h0);
        chk("R6 no auto-precharge", 64'(bank_open), 64'h1);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b11);
        chk("R11 no beat", 64'(wr_mask), 64'h0);
        chk("R12 no read oe", 64'(rd_oe), 64'h0);

        // R6 R12 read with auto-precharge and lane masks
        step(1'b1, C_RD, 2'd0, 13'h04F1, 2'b00);
        chk("R5 read col0", 64'(burst_col), 64'h0F1);
        chk("R11 read no mask", 64'(wr_mask), 64'h0);
        chk("R12 oe s0", 64'(rd_oe), 64'h0);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b10);
        chk("R12 oe s1", 64'(rd_oe), 64'h0);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b00);
        chk("R12 oe s2", 64'(rd_oe), 64'h3);
        chk("R6 still open", 64'(bank_open), 64'h1);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b01);
        chk("R12 oe s3", 64'(rd_oe), 64'h1);
        chk("R5 read col3", 64'(burst_col), 64'h0F0);
        chk("R6 closed at last beat", 64'(bank_open), 64'h0);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b00);
        chk("R12 oe s4", 64'(rd_oe), 64'h3);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b00);
        chk("R12 oe s5", 64'(rd_oe), 64'h2);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b00);
        chk("R12 oe s6", 64'(rd_oe), 64'h0);

        // R9 R10 clock suspend during a write burst
        step(1'b1, C_ACT, 2'd1, 13'h0009, 2'b00);
        step(1'b1, C_WR, 2'd1, 13'h0000, 2'b00);
        chk("R5 suspend col0", 64'(burst_col), 64'h000);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b00);
        chk("R5 suspend col1", 64'(burst_col), 64'h001);
        step(1'b0, C_NOP, 2'd0, 13'h0000, 2'b11);
        chk("R9 suspend entry", 64'(pwr_state), 64'h4);
        chk("R10 col frozen", 64'(burst_col), 64'h001);
        chk("R11 no mask in suspend", 64'(wr_mask), 64'h0);
        step(1'b0, C_PRE, 2'd1, 13'h0400, 2'b00);
        chk("R10 still suspended", 64'(pwr_state), 64'h4);
        chk("R10 precharge ignored", 64'(bank_open), 64'h2);
        chk("R10 burst held", 64'(burst_active), 64'h1);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b10);
        chk("R10 wake", 64'(pwr_state), 64'h0);
        chk("R10 resume col", 64'(burst_col), 64'h002);
        chk("R11 resume mask", 64'(wr_mask), 64'h2);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b00);
        chk("R5 final col", 64'(burst_col), 64'h003);
        chk("R5 burst over", 64'(burst_active), 64'h0);
        chk("R6 bank stays open", 64'(bank_open), 64'h2);

        // R4 write to idle bank
        step(1'b1, C_WR, 2'd2, 13'h0003, 2'b11);
        chk("R4 error", 64'(cmd_err), 64'h1);
        chk("R4 no burst", 64'(burst_active), 64'h0);
        chk("R4 no mask", 64'(wr_mask), 64'h0);
        step(1'b1, C_NOP, 2'd0, 13'h0000, 2'b00);
        chk("R13 pulse ends", 64'(cmd_err), 64'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule